// File: doc/BRIEF.md
# Video Capture Field Address Controller

This block holds the configuration and status of an interlaced video capture port that writes fields into memory. A small word-addressed register port gives software access to two field base addresses (odd and even), a line target, the current line count and a status word. The capture datapath supplies field-start, field-parity, line-stored and first-data strobes. In return the block provides the base address of the field being captured and a line interrupt.

Base address writes are double-buffered. A write lands in a pending shadow and raises a pending flag. Both fields' pending values move into the active registers together, on the first data write of the next field. The start of a field does not move them. A line counter tracks the line being stored and restarts at every field start. A one-cycle interrupt fires when the count reaches the programmed target, and a sticky status bit records the event until software writes 1 to clear it.

Register map (word address on `reg_addr`):
- 0 status: bit0 capture running, bit1 data being written, bit2 base pending, bit3 line-hit sticky (write 1 clears). All other bits read 0.
- 1 current line (bits 9:0, read only).
- 2 line target (bits 9:0).
- 3 odd base.
- 4 even base. Base reads return the active value.
- 5 to 7 read 0.

Top module: `vcap_field_addr`

## Requirements
- R1: After reset, every register reads 0, `active_base` is 0, `line_irq` is 0 and `base_pending` is 0.
- R2: A write to address 3 or 4 leaves that address's readback and `active_base` at their old values. From the next cycle it sets `base_pending` and status bit2.
- R3: A `first_data` strobe while a write is pending copies both pending bases into the active registers in the same edge and clears the pending flag. A `field_start` alone commits nothing.
- R4: A second write to a base before commit replaces the first; only the latest value is committed.
- R5: A base write in the same cycle as `first_data` stays pending with the flag set. Any earlier pending value of the other field commits at that edge, and the new value commits on the following `first_data`.
- R6: Bits 3:0 of both base addresses are always 0, on readback and on `active_base`.
- R7: The line count rises by one per `line_stored` strobe and returns to 0 on `field_start`. `field_start` wins over a simultaneous `line_stored`.
- R8: `line_irq` is high for exactly one cycle, in the cycle in which the line count first shows a new value equal to the target.
- R9: Status bit3 sets with each line hit. Writing 1 to it clears it, writing 0 has no effect, and a hit in the same cycle as a clear leaves it set.
- R10: `active_base` is the odd base when the parity sampled at the last `field_start` was 1 (odd) and the even base when it was 0.
- R11: Status bits 0 and 1 follow `cap_run` and `cap_active`. The target keeps only bits 9:0. Reserved bits and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| field_start | input | 1 | Start of a new field |
| field_odd | input | 1 | Parity of the starting field, sampled with `field_start` |
| line_stored | input | 1 | One line has been stored |
| first_data | input | 1 | First data of the field written to memory |
| cap_run | input | 1 | Capture in progress |
| cap_active | input | 1 | Data currently being written |
| active_base | output | 32 | Base address of the field being captured |
| line_irq | output | 1 | One-cycle line-hit interrupt |
| base_pending | output | 1 | A base write awaits commit |

## Verification
The bench targets the commit point. If base writes were applied straight away, or committed on field start, the readback after the write or after `field_start` would show the new value too early. A write coinciding with `first_data` is checked to stay pending; a design that merged it into the commit would clear the flag. Rewriting a base before commit checks that the last value wins, not the first. The line hit is checked for its exact cycle and for a single pulse, the field-start-over-line priority is checked, and a hit racing a write-1 clear must leave the sticky bit set.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  localparam int BASE_W    = 32;
  localparam int ALIGN_LSB = 4;
  localparam int LINE_W    = 10;
  localparam int REG_AW    = 3;
  localparam int N_FIELDS  = 2;

  localparam int FLD_EVEN = 0;
  localparam int FLD_ODD  = 1;

  typedef enum logic [REG_AW-1:0] {
    RA_STATUS    = 3'd0,
    RA_LINE      = 3'd1,
    RA_TARGET    = 3'd2,
    RA_BASE_ODD  = 3'd3,
    RA_BASE_EVEN = 3'd4
  } reg_addr_e;

  localparam int ST_RUN  = 0;
  localparam int ST_WRAC = 1;
  localparam int ST_PEND = 2;
  localparam int ST_HIT  = 3;
endpackage

// File: rtl/vcap_base_bank.sv
module vcap_base_bank #(
  parameter int BASE_W    = vcap_pkg::BASE_W,
  parameter int ALIGN_LSB = vcap_pkg::ALIGN_LSB,
  parameter int NFLD      = vcap_pkg::N_FIELDS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NFLD-1:0]            wr_en,
  input  logic [BASE_W-1:0]          wdata,
  input  logic                       commit_req,
  output logic [NFLD-1:0][BASE_W-1:0] active_q,
  output logic                       dirty_q,
  output logic                       commit_evt
);
  function automatic logic [BASE_W-1:0] align_base(input logic [BASE_W-1:0] a);
    return {a[BASE_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
  endfunction

  logic any_wr;
  assign any_wr     = |wr_en;
  assign commit_evt = commit_req & dirty_q;

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    logic [BASE_W-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q      <= '0;
        active_q[f] <= '0;
      end else begin
        if (commit_evt) active_q[f] <= pend_q;
        if (wr_en[f])   pend_q      <= align_base(wdata);
      end
    end

    assert_base_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
      active_q[f][ALIGN_LSB-1:0] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          dirty_q <= 1'b0;
    else if (any_wr)     dirty_q <= 1'b1;
    else if (commit_evt) dirty_q <= 1'b0;
  end

  assert_write_sets_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> dirty_q);
  assert_commit_clears_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && !any_wr) |=> !dirty_q);
  assert_active_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(active_q));
endmodule

// File: rtl/vcap_line_tracker.sv
module vcap_line_tracker #(
  parameter int LINE_W = vcap_pkg::LINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              line_stored,
  input  logic [LINE_W-1:0] target,
  output logic [LINE_W-1:0] cur_line,
  output logic              hit_evt,
  output logic              irq_q
);
  function automatic logic [LINE_W-1:0] line_step(input logic [LINE_W-1:0] c,
                                                  input logic start, input logic stored);
    if (start)       return '0;
    else if (stored) return c + LINE_W'(1);
    else             return c;
  endfunction

  logic [LINE_W-1:0] cnt_q, cnt_nxt;
  assign cnt_nxt  = line_step(cnt_q, field_start, line_stored);
  assign hit_evt  = (cnt_nxt != cnt_q) && (cnt_nxt == target);
  assign cur_line = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      irq_q <= hit_evt;
    end
  end

  assert_field_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> cnt_q == '0);
  assert_line_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_stored && !field_start) |=> cnt_q == $past(cnt_q) + LINE_W'(1));
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  assert_irq_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> cnt_q != $past(cnt_q));
endmodule

// File: rtl/vcap_field_addr.sv
module vcap_field_addr #(
  parameter int BASE_W    = vcap_pkg::BASE_W,
  parameter int ALIGN_LSB = vcap_pkg::ALIGN_LSB,
  parameter int LINE_W    = vcap_pkg::LINE_W,
  parameter int REG_AW    = vcap_pkg::REG_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              field_start,
  input  logic              field_odd,
  input  logic              line_stored,
  input  logic              first_data,
  input  logic              cap_run,
  input  logic              cap_active,
  output logic [BASE_W-1:0] active_base,
  output logic              line_irq,
  output logic              base_pending
);
  import vcap_pkg::*;

  localparam int NF = N_FIELDS;

  logic [NF-1:0]            wr_base;
  logic                     wr_target, wr_status;
  logic [NF-1:0][BASE_W-1:0] bases;
  logic                     dirty, commit_evt;
  logic [LINE_W-1:0]        target_q, cur_line;
  logic                     hit_evt, sticky_q, cur_odd_q;

  assign wr_status        = reg_wr && (reg_addr == RA_STATUS);
  assign wr_target        = reg_wr && (reg_addr == RA_TARGET);
  assign wr_base[FLD_ODD]  = reg_wr && (reg_addr == RA_BASE_ODD);
  assign wr_base[FLD_EVEN] = reg_wr && (reg_addr == RA_BASE_EVEN);

  vcap_base_bank #(.BASE_W(BASE_W), .ALIGN_LSB(ALIGN_LSB), .NFLD(NF)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_base), .wdata(reg_wdata[BASE_W-1:0]),
    .commit_req(first_data), .active_q(bases), .dirty_q(dirty), .commit_evt(commit_evt)
  );

  vcap_line_tracker #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_stored(line_stored),
    .target(target_q), .cur_line(cur_line), .hit_evt(hit_evt), .irq_q(line_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q  <= '0;
      sticky_q  <= 1'b0;
      cur_odd_q <= 1'b0;
    end else begin
      if (wr_target)   target_q  <= reg_wdata[LINE_W-1:0];
      if (field_start) cur_odd_q <= field_odd;
      if (hit_evt)                         sticky_q <= 1'b1;
      else if (wr_status && reg_wdata[ST_HIT]) sticky_q <= 1'b0;
    end
  end

  assign active_base  = cur_odd_q ? bases[FLD_ODD] : bases[FLD_EVEN];
  assign base_pending = dirty;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_STATUS: begin
        reg_rdata[ST_RUN]  = cap_run;
        reg_rdata[ST_WRAC] = cap_active;
        reg_rdata[ST_PEND] = dirty;
        reg_rdata[ST_HIT]  = sticky_q;
      end
      RA_LINE:      reg_rdata[LINE_W-1:0] = cur_line;
      RA_TARGET:    reg_rdata[LINE_W-1:0] = target_q;
      RA_BASE_ODD:  reg_rdata[BASE_W-1:0] = bases[FLD_ODD];
      RA_BASE_EVEN: reg_rdata[BASE_W-1:0] = bases[FLD_EVEN];
      default:      reg_rdata = '0;
    endcase
  end

  assert_irq_marks_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq |-> sticky_q);
  assert_parity_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> cur_odd_q == $past(field_odd));
  assert_out_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active_base[ALIGN_LSB-1:0] == '0);
  assert_no_commit_without_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !first_data |=> $stable(bases));
endmodule

// File: tb/vcap_field_addr_tb.sv
`timescale 1ns/1ps
module vcap_field_addr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        field_start = 1'b0, field_odd = 1'b0, line_stored = 1'b0, first_data = 1'b0;
  logic        cap_run = 1'b0, cap_active = 1'b0;
  logic [31:0] active_base;
  logic        line_irq, base_pending;

  always #2 clk = ~clk;

  vcap_field_addr u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .field_start(field_start), .field_odd(field_odd),
    .line_stored(line_stored), .first_data(first_data), .cap_run(cap_run),
    .cap_active(cap_active), .active_base(active_base), .line_irq(line_irq),
    .base_pending(base_pending)
  );

  // kind: 0 register read, 1 active_base, 2 line_irq, 3 base_pending
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // monitor: pops expectations pushed this cycle and compares away from the edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = reg_rdata;
        1:       act = active_base;
        2:       act = {31'd0, line_irq};
        default: act = {31'd0, base_pending};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind%0d: actual %h expected %h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic exp_out(input int kind, input logic [31:0] e, input string r);
    item_t it;
    it.kind = kind; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic exp_reg(input logic [2:0] a, input logic [31:0] e, input string r);
    reg_addr = a;
    exp_out(0, e, r);
    step();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic pulse_line();
    line_stored = 1'b1; step(); line_stored = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    exp_out(1, 32'h0, "R1"); exp_out(2, 32'h0, "R1"); exp_out(3, 32'h0, "R1");
    exp_reg(3'd0, 32'h0, "R1");
    exp_reg(3'd1, 32'h0, "R1");
    exp_reg(3'd2, 32'h0, "R1");
    exp_reg(3'd3, 32'h0, "R1");
    exp_reg(3'd4, 32'h0, "R1");

    // R11 status inputs, reserved, target masking
    cap_run = 1'b1; cap_active = 1'b1;
    exp_reg(3'd0, 32'h3, "R11");
    exp_reg(3'd5, 32'h0, "R11");
    wr(3'd2, 32'hFFFF_F405);
    exp_reg(3'd2, 32'h005, "R11");
    wr(3'd2, 32'd3);

    // R2 write goes to pending only
    wr(3'd3, 32'h1234_567F);
    exp_out(3, 32'h1, "R2"); exp_out(1, 32'h0, "R2");
    exp_reg(3'd3, 32'h0, "R2");
    exp_reg(3'd0, 32'h7, "R2");
    // R4 rewrite before commit, plus even write
    wr(3'd3, 32'h0000_A00F);
    wr(3'd4, 32'h0000_B001);

    // R3 field start alone commits nothing
    field_start = 1'b1; field_odd = 1'b1; step(); field_start = 1'b0;
    exp_reg(3'd3, 32'h0, "R3");
    exp_out(3, 32'h1, "R3");
    exp_reg(3'd4, 32'h0, "R3");
    // R3 commit on first data, both fields together
    first_data = 1'b1; step(); first_data = 1'b0;
    exp_out(3, 32'h0, "R3"); exp_out(1, 32'h0000_A000, "R10");
    exp_reg(3'd3, 32'h0000_A000, "R4");
    exp_reg(3'd4, 32'h0000_B000, "R6");

    // R7/R8 line counting and interrupt at target 3
    pulse_line();
    exp_out(2, 32'h0, "R8");
    exp_reg(3'd1, 32'd1, "R7");
    pulse_line();
    exp_reg(3'd1, 32'd2, "R7");
    pulse_line();
    exp_out(2, 32'h1, "R8");
    reg_addr = 3'd1; exp_out(0, 32'd3, "R7");
    step();
    exp_out(2, 32'h0, "R8");
    // R9 sticky and write-1 clear
    exp_reg(3'd0, 32'hB, "R9");
    wr(3'd0, 32'h0);
    exp_reg(3'd0, 32'hB, "R9");
    wr(3'd0, 32'h8);
    exp_reg(3'd0, 32'h3, "R9");

    // R7 field_start beats line_stored; R10 even parity
    field_start = 1'b1; field_odd = 1'b0; line_stored = 1'b1;
    step();
    field_start = 1'b0; line_stored = 1'b0;
    exp_out(1, 32'h0000_B000, "R10");
    exp_out(2, 32'h0, "R8");
    exp_reg(3'd1, 32'd0, "R7");

    // R5 base write coinciding with first_data
    wr(3'd4, 32'h0000_B100);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'hC0DE_0007; first_data = 1'b1;
    step();
    reg_wr = 1'b0; first_data = 1'b0;
    exp_out(3, 32'h1, "R5"); exp_out(1, 32'h0000_B100, "R5");
    exp_reg(3'd3, 32'h0000_A000, "R5");
    exp_reg(3'd4, 32'h0000_B100, "R5");
    first_data = 1'b1; step(); first_data = 1'b0;
    exp_out(3, 32'h0, "R5");
    exp_reg(3'd3, 32'hC0DE_0000, "R5");

    // R9 hit in same cycle as clear keeps sticky set
    wr(3'd2, 32'd1);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h8; line_stored = 1'b1;
    step();
    reg_wr = 1'b0; line_stored = 1'b0;
    exp_out(2, 32'h1, "R8");
    exp_reg(3'd0, 32'hB, "R9");
    pulse_line();
    exp_out(2, 32'h0, "R8");
    exp_reg(3'd1, 32'd2, "R7");

    step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule